// File: doc/BRIEF.md
# Chip-Select Address Window Decoder

This block sits between a flat memory-mapped flash window and up to five serial flash chip selects. Each chip select owns one range register that places its segment inside the window with a granularity of one megabyte. A lookup presents an offset into the window. One clock later the block reports which chip select owns that offset and the offset measured from the start of that segment. If no segment owns the offset, it reports a miss. If several segments claim it, it reports an overlap.

Software programs the range registers through a simple write port. A range register packs two eight-bit megabyte numbers: the first megabyte of the segment and the last megabyte of the segment, both inclusive. A register whose two fields are both zero turns the chip select off. The block refuses any nonzero setting that would break the layout rules: a segment must span at least two megabytes, and it must start on a multiple of its own size. A refused write leaves the register unchanged. The lookup side then only ever sees well-formed segments.

Top module: `csdec_window`

## Requirements
- R1: After a synchronous active-low reset, every chip select is off and `rsp_valid`, `rsp_hit`, `rsp_miss`, `rsp_overlap`, `rsp_cs` and `rsp_rel` are all zero. Lookups made before any register write report a miss.
- R2: A write stores only two fields of `cfg_wdata`: bits 11:4 hold the first megabyte and bits 27:20 hold the last megabyte, both inclusive. All other data bits have no effect on decoding.
- R3: A lookup hits chip select i when i is on and bits 27:20 of `req_offset` lie between that segment's first and last megabyte, inclusive. `rsp_cs` then gives i.
- R4: On a hit, `rsp_rel` equals `req_offset` minus the segment's first megabyte times 2^20, taken modulo 2^28.
- R5: Writing a value whose two fields are both zero turns that chip select off. Offsets it used to own then go to another segment or miss.
- R6: When more than one enabled segment contains the offset, the lowest chip-select index is reported and `rsp_overlap` is 1. With exactly one match, `rsp_overlap` is 0.
- R7: When no enabled segment contains the offset, `rsp_miss` is 1, `rsp_hit` is 0, `rsp_overlap` is 0, `rsp_cs` is 0 and `rsp_rel` is all ones.
- R8: A write whose `cfg_sel` is 5, 6 or 7 changes no range register.
- R9: A write with nonzero fields is refused, leaving the register unchanged, if the last megabyte is not greater than the first. This covers segments smaller than two megabytes and reversed segments.
- R10: A write with nonzero fields is refused, leaving the register unchanged, if the first megabyte is not a multiple of the segment size in megabytes (last minus first plus one).
- R11: `rsp_valid` and the result fields for a lookup appear on the clock edge after the edge that samples `req_valid`. `rsp_valid` is 0 in any cycle whose previous cycle had no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Range register write strobe |
| cfg_sel | input | 3 | Index of the range register to write |
| cfg_wdata | input | 32 | Range register write value (first MB in 11:4, last MB in 27:20) |
| req_valid | input | 1 | Lookup request strobe |
| req_offset | input | 28 | Offset into the flash window |
| rsp_valid | output | 1 | Lookup result is valid this cycle |
| rsp_hit | output | 1 | Offset belongs to an enabled segment |
| rsp_cs | output | 3 | Chip-select index that owns the offset |
| rsp_rel | output | 28 | Offset relative to the segment start, all ones on a miss |
| rsp_miss | output | 1 | No enabled segment contains the offset |
| rsp_overlap | output | 1 | More than one enabled segment contains the offset |

## Verification
A register write takes effect on the edge that samples it, so a lookup may follow in the very next cycle. Every lookup result is due exactly one edge after its request is sampled. The bench changes inputs on the falling edge, releases the request on the next falling edge, and compares all result fields at that point, which lies half a period after the single register stage. One further falling edge later it confirms that the valid strobe has dropped. Every megabyte of the window is swept under several register layouts, and the expected owner, relative offset, miss and overlap values are computed from the bench's own copy of the accepted ranges.

// File: rtl/csdec_pkg.sv
// Package: shared constants and the segment descriptor for the window decoder.
// Assumes a 28-bit window offset split into an 8-bit megabyte number above
// bit 20; modules take these as parameter defaults.
package csdec_pkg;
    localparam int CSD_NUM_CS = 5;
    localparam int CSD_OFF_W  = 28;
    localparam int CSD_MB_LSB = 20;
    localparam int CSD_REG_W  = 32;
    localparam int CSD_MB_W   = CSD_OFF_W - CSD_MB_LSB;

    // One decoded segment: enable plus inclusive first/last megabyte.
    typedef struct packed {
        logic                en;
        logic [CSD_MB_W-1:0] last_mb;
        logic [CSD_MB_W-1:0] first_mb;
    } seg_t;
endpackage

// File: rtl/csdec_range_reg.sv
// Module: one chip select's range register.
// Extracts the first/last megabyte fields from a write, accepts an all-zero
// pair (disable) or a legal segment (at least two units long, start aligned to
// its own size) and drops anything else. Assumes one write per cycle at most.
module csdec_range_reg
    import csdec_pkg::*;
#(
    parameter int OFF_W  = CSD_OFF_W,
    parameter int MB_LSB = CSD_MB_LSB,
    parameter int REG_W  = CSD_REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output seg_t             seg
);
    localparam int MB_W      = OFF_W - MB_LSB;
    localparam int FIRST_LSB = MB_LSB - 16;

    logic [MB_W-1:0] wr_first;
    logic [MB_W-1:0] wr_last;
    logic [MB_W:0]   wr_size;
    logic            wr_clear;
    logic            wr_legal;

    // Field extraction and layout legality of the incoming write.
    always_comb begin
        wr_first = wr_data[FIRST_LSB +: MB_W];
        wr_last  = wr_data[MB_LSB +: MB_W];
        wr_clear = (wr_first == '0) && (wr_last == '0);
        wr_size  = {1'b0, wr_last} - {1'b0, wr_first} + {{MB_W{1'b0}}, 1'b1};
        if (wr_last > wr_first) begin
            wr_legal = (({1'b0, wr_first} % wr_size) == '0);
        end else begin
            wr_legal = 1'b0;
        end
    end

    // Register update: disable, load a legal segment, or keep contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg <= '0;
        end else if (wr_en && wr_clear) begin
            seg <= '0;
        end else if (wr_en && wr_legal) begin
            seg.en       <= 1'b1;
            seg.first_mb <= wr_first;
            seg.last_mb  <= wr_last;
        end
    end

    // An enabled segment always spans at least two units (R9).
    p_seg_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seg.en |-> (seg.last_mb > seg.first_mb));

    // A refused write leaves the register untouched (R9, R10).
    p_bad_write_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_clear && !wr_legal) |=> $stable(seg));

    // A disabled register carries all-zero fields (R5).
    p_off_is_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !seg.en |-> (seg.first_mb == '0 && seg.last_mb == '0));
endmodule

// File: rtl/csdec_seg_match.sv
// Module: compares one window offset against one segment.
// Produces the hit flag and the offset relative to the segment's first
// megabyte. Purely combinational; assumes the segment is well formed.
module csdec_seg_match
    import csdec_pkg::*;
#(
    parameter int OFF_W  = CSD_OFF_W,
    parameter int MB_LSB = CSD_MB_LSB
) (
    input  seg_t             seg,
    input  logic [OFF_W-1:0] offset,
    output logic             hit,
    output logic [OFF_W-1:0] rel
);
    localparam int MB_W = OFF_W - MB_LSB;

    logic [MB_W-1:0] off_mb;

    // Inclusive range compare and relative offset subtraction.
    always_comb begin
        off_mb = offset[MB_LSB +: MB_W];
        hit    = seg.en && (off_mb >= seg.first_mb) && (off_mb <= seg.last_mb);
        rel    = offset - {seg.first_mb, {MB_LSB{1'b0}}};
    end
endmodule

// File: rtl/csdec_prio.sv
// Module: lowest-index priority pick over the per-segment hits.
// Reports whether any segment hit, the winning index, its relative offset
// and whether two or more segments hit at once.
module csdec_prio #(
    parameter int N     = 5,
    parameter int OFF_W = 28,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]       hit,
    input  logic [N*OFF_W-1:0] rel_flat,
    output logic               any,
    output logic [IDX_W-1:0]   idx,
    output logic [OFF_W-1:0]   sel_rel,
    output logic               multi
);
    // Scan from the top so the lowest hitting index is the last assignment.
    always_comb begin
        any     = 1'b0;
        idx     = '0;
        sel_rel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) begin
                any     = 1'b1;
                idx     = IDX_W'(i);
                sel_rel = rel_flat[i*OFF_W +: OFF_W];
            end
        end
        multi = |(hit & (hit - N'(1)));
    end
endmodule

// File: rtl/csdec_window.sv
// Module: chip-select address window decoder (top).
// Holds NUM_CS range registers, decodes every lookup against all of them in
// parallel and registers the result one cycle later. Assumes a single writer
// on the configuration port and at most one lookup per cycle.
module csdec_window
    import csdec_pkg::*;
#(
    parameter int NUM_CS = CSD_NUM_CS,
    parameter int OFF_W  = CSD_OFF_W,
    parameter int MB_LSB = CSD_MB_LSB,
    parameter int REG_W  = CSD_REG_W,
    parameter int IDX_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_sel,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             req_valid,
    input  logic [OFF_W-1:0] req_offset,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [IDX_W-1:0] rsp_cs,
    output logic [OFF_W-1:0] rsp_rel,
    output logic             rsp_miss,
    output logic             rsp_overlap
);
    seg_t [NUM_CS-1:0]       segs;
    logic [NUM_CS-1:0]       hits;
    logic [NUM_CS*OFF_W-1:0] rels;
    logic                    any_hit;
    logic [IDX_W-1:0]        win_idx;
    logic [OFF_W-1:0]        win_rel;
    logic                    many_hit;

    // One range register and one comparator per chip select.
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        logic sel_me;
        assign sel_me = cfg_we && (cfg_sel == IDX_W'(g));

        csdec_range_reg #(
            .OFF_W (OFF_W),
            .MB_LSB(MB_LSB),
            .REG_W (REG_W)
        ) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (sel_me),
            .wr_data(cfg_wdata),
            .seg    (segs[g])
        );

        csdec_seg_match #(
            .OFF_W (OFF_W),
            .MB_LSB(MB_LSB)
        ) u_match (
            .seg   (segs[g]),
            .offset(req_offset),
            .hit   (hits[g]),
            .rel   (rels[g*OFF_W +: OFF_W])
        );
    end

    csdec_prio #(
        .N    (NUM_CS),
        .OFF_W(OFF_W),
        .IDX_W(IDX_W)
    ) u_prio (
        .hit     (hits),
        .rel_flat(rels),
        .any     (any_hit),
        .idx     (win_idx),
        .sel_rel (win_rel),
        .multi   (many_hit)
    );

    // Result register: owner, relative offset, miss fill and overlap flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_hit     <= 1'b0;
            rsp_miss    <= 1'b0;
            rsp_overlap <= 1'b0;
            rsp_cs      <= '0;
            rsp_rel     <= '0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_hit     <= req_valid && any_hit;
            rsp_miss    <= req_valid && !any_hit;
            rsp_overlap <= req_valid && many_hit;
            if (req_valid) begin
                rsp_cs  <= any_hit ? win_idx : '0;
                rsp_rel <= any_hit ? win_rel : '1;
            end
        end
    end

    // A result only follows a sampled request (R11).
    p_rsp_after_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    // Hit and miss are flags of a valid result and exclude each other (R7).
    p_flags_need_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit || rsp_miss) |-> (rsp_valid && (rsp_hit != rsp_miss)));

    // A miss carries the fill pattern and no owner (R7).
    p_miss_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_rel == '1 && rsp_cs == '0 && !rsp_overlap));

    // Overlap is only reported together with a hit (R6).
    p_overlap_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_overlap |-> rsp_hit);

    // Writes to an index with no register leave every segment as it was (R8).
    p_cfg_oob_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (int'(cfg_sel) >= NUM_CS)) |=> $stable(segs));
endmodule

// File: tb/sim_csdec_window.sv
module sim_csdec_window;
    localparam int NCS  = 5;
    localparam int OFFW = 28;
    localparam int REGW = 32;
    localparam int IW   = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [IW-1:0]   cfg_sel = '0;
    logic [REGW-1:0] cfg_wdata = '0;
    logic            req_valid = 1'b0;
    logic [OFFW-1:0] req_offset = '0;
    logic            rsp_valid, rsp_hit, rsp_miss, rsp_overlap;
    logic [IW-1:0]   rsp_cs;
    logic [OFFW-1:0] rsp_rel;

    int n_chk = 0;
    int n_fail = 0;
    int m_first[NCS];
    int m_last[NCS];
    bit m_en[NCS];

    always #4 clk = ~clk;

    csdec_window u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_offset(req_offset),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_cs(rsp_cs),
        .rsp_rel(rsp_rel), .rsp_miss(rsp_miss), .rsp_overlap(rsp_overlap)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write a range register; fields go to 11:4 (first) and 27:20 (last).
    task automatic wr(input int idx, input int f, input int l, input logic [31:0] junk);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_sel   = IW'(idx);
        cfg_wdata = (junk & ~32'h0FF0_0FF0) | (32'(l & 255) << 20) | (32'(f & 255) << 4);
        @(negedge clk);
        cfg_we = 1'b0;
        if (idx < NCS) begin
            if ((f == 0) && (l == 0)) begin
                m_en[idx] = 1'b0; m_first[idx] = 0; m_last[idx] = 0;
            end else if ((l > f) && ((f % (l - f + 1)) == 0)) begin
                m_en[idx] = 1'b1; m_first[idx] = f; m_last[idx] = l;
            end
        end
    endtask

    task automatic look(input logic [OFFW-1:0] off, input string tag);
        int mb, nhit, win;
        logic [63:0] act, exp;
        logic [OFFW-1:0] erel;
        string req;
        mb = int'(off[27:20]);
        nhit = 0; win = 0;
        for (int i = NCS - 1; i >= 0; i--) begin
            if (m_en[i] && mb >= m_first[i] && mb <= m_last[i]) begin
                nhit++; win = i;
            end
        end
        erel = (nhit > 0) ? off - (28'(m_first[win]) << 20) : '1;
        exp = {27'd0, 1'b1, (nhit > 0), (nhit == 0), (nhit > 1),
               IW'((nhit > 0) ? win : 0), erel};
        if (nhit == 0)      req = {"R7 ", tag};
        else if (nhit > 1)  req = {"R6 ", tag};
        else                req = {"R3 R4 ", tag};
        @(negedge clk);
        req_valid = 1'b1; req_offset = off;
        @(negedge clk);
        req_valid = 1'b0;
        act = {27'd0, rsp_valid, rsp_hit, rsp_miss, rsp_overlap, rsp_cs, rsp_rel};
        chk(act == exp, req, act, exp);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R11 valid drops", 64'(rsp_valid), 64'd0);
    endtask

    task automatic sweep(input string tag);
        for (int mb = 0; mb < 256; mb++) begin
            logic [19:0] lo;
            lo = (mb % 3 == 0) ? 20'd0 : (mb % 3 == 1) ? 20'hFFFFF : 20'(mb * 4099);
            look({8'(mb), lo}, tag);
        end
    endtask

    initial begin
        for (int i = 0; i < NCS; i++) begin
            m_en[i] = 1'b0; m_first[i] = 0; m_last[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({rsp_valid, rsp_hit, rsp_miss, rsp_overlap, rsp_cs, rsp_rel} == '0,
            "R1 reset outputs",
            64'({rsp_valid, rsp_hit, rsp_miss, rsp_overlap, rsp_cs, rsp_rel}), 64'd0);
        // R1: nothing is decoded before the first write
        look(28'h0000000, "R1");
        look(28'h3F12345, "R1");
        look(28'hFFFFFFF, "R1");

        // R2: junk outside the two fields is ignored; tiled legal layout
        wr(0, 0, 1, 32'hF000_F00F);
        wr(1, 2, 3, 32'h0000_0000);
        wr(2, 4, 7, 32'h5005_A00A);
        wr(3, 8, 15, 32'h0000_0000);
        wr(4, 16, 31, 32'h3000_0001);
        sweep("R2");

        // R9 and R10: illegal layouts are refused; R8: out-of-range indices
        wr(2, 5, 5, 32'h0);
        wr(4, 40, 20, 32'h0);
        wr(3, 3, 4, 32'h0);
        wr(1, 6, 9, 32'h0);
        wr(5, 64, 127, 32'h0);
        wr(6, 128, 191, 32'h0);
        wr(7, 192, 255, 32'h0);
        sweep("R8 R9 R10");
        wr(4, 48, 63, 32'h0);
        sweep("R3");

        // R5: zero fields switch cs0 off; R6: cs1 and cs2 overlap
        wr(0, 0, 0, 32'hF00F_F00F);
        wr(1, 0, 3, 32'h0);
        wr(2, 0, 7, 32'h0);
        wr(3, 96, 127, 32'h0);
        sweep("R5 R6");

        // R6: cs0 spans the whole window and wins everywhere
        wr(0, 0, 255, 32'h0);
        sweep("R6");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule